// File: doc/BRIEF.md
# Page-Buffered Self-Timed Write Controller

This block sits behind the serial front end of a small serial memory. It turns a decoded write command into a timed commit to the storage array. The front end gives one tick per serial clock while the device is selected. It also gives a pulse when a write opcode and its byte address have been received, and a pulse with each complete data byte. The controller collects those bytes into a page buffer whose slot pointer wraps inside the page. It remembers which slots received data.

When the select line is released, the controller checks the serial clock count. If the count matches a whole number of data bytes after the 16-bit header, the buffered write is committed. The controller then runs a programming cycle whose length is counted in system clocks. During the first cycles it writes only the filled slots into the array, one per clock. It reports busy for the whole cycle and refuses all commands. At the end it drops the write-enable latch. Any other count discards the write.

The write-protect input cancels a write that is still being collected, but it cannot stop a cycle that has already started. A power-up lockout keeps writes out for a set number of clocks after reset.

Top module: `pgwr_top`

## Requirements
- R1: After reset, busy, wenLatch, cmdReject and arrWe are all 0.
- R2: While not busy, a wenSet pulse with wpN high sets wenLatch. A wenClr pulse clears it. wpN low clears it.
- R3: A wrCmd pulse starts a write only if wenLatch is 1, wpN is 1, the device is selected and the controller is idle. Otherwise no array write results.
- R4: A wrCmd arriving before PWRUP_CLKS clocks have passed since reset is ignored, and the later deselect starts no cycle.
- R5: A cycle starts on deselect only when the serial clock count at that moment is 16 + 8k, with k from 1 to PAGE_BYTES (24, 32, 40 or 48 by default). Any other count discards the write and leaves wenLatch unchanged.
- R6: Data byte i (counting from 0) of a write to address A lands at the address whose upper bits are those of A and whose two low bits are (A[1:0] + i) mod 4.
- R7: In a cycle, only the slots that received data are written. There is one array write per received byte (up to PAGE_BYTES), and all of them fall in the first PAGE_BYTES busy cycles.
- R8: wpN low while a write is being collected cancels it and clears wenLatch. wpN low during a running cycle does not stop the array writes.
- R9: busy rises in the clock after the deselect and stays high for exactly CYC_CLKS clocks.
- R10: A wrCmd, wenSet or wenClr pulse while busy is rejected. cmdReject is 1 in the following clock, and wenLatch does not rise because of it.
- R11: wenLatch is 0 once busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selActive | input | 1 | 1 while the device is selected on the serial bus |
| bitTick | input | 1 | One-clock pulse per serial clock rising edge |
| wrCmd | input | 1 | Pulse: write opcode and address have been received |
| cmdAddr | input | ADDR_W | Byte address captured with wrCmd |
| dataValid | input | 1 | Pulse: a complete data byte is on dataByte |
| dataByte | input | DATA_W | Received data byte |
| wenSet | input | 1 | Pulse: write-enable command decoded |
| wenClr | input | 1 | Pulse: write-disable command decoded |
| wpN | input | 1 | Write protect, active low |
| busy | output | 1 | Programming cycle in progress |
| wenLatch | output | 1 | Write-enable latch state |
| cmdReject | output | 1 | A command arrived during the cycle (one clock later) |
| arrWe | output | 1 | Array write strobe |
| arrAddr | output | ADDR_W | Array write address |
| arrData | output | DATA_W | Array write data |

## Verification
A wrong bit counter or wrong legality decode shows up one clock after deselect. busy either rises when it should not or stays low when it should rise. A fault in the slot pointer or the valid mask shows as a wrong byte or a stray byte in the page within the first four busy clocks. A timer fault shows as a busy length other than CYC_CLKS when busy falls. A latch fault shows on wenLatch at once or at the end of the cycle. Random writes at random page offsets and counts, checked against a bench memory model, reach these states together.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int PAGE_BYTES = 4;
  localparam int SLOT_W     = $clog2(PAGE_BYTES);
  localparam int BYTE_W     = 8;
  localparam int HDR_BITS   = 2 * BYTE_W;

  typedef struct packed {
    logic              loadBase;
    logic              storeByte;
    logic              drainEn;
    logic [SLOT_W-1:0] drainIdx;
  } dpCtrl_t;
endpackage

// File: rtl/pgwr_datapath.sv
module pgwr_datapath
  import pgwr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selActive,
  input  logic              bitTick,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] dataByte,
  input  dpCtrl_t           ctl,
  output logic              deselEvent,
  output logic              legalCount,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);
  localparam int CNT_MAX = HDR_BITS + BYTE_W * PAGE_BYTES + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BASE_W  = ADDR_W - SLOT_W;

  logic [CNT_W-1:0]  bitCnt;
  logic              selPrev;
  logic [DATA_W-1:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [SLOT_W-1:0] slotPtr;
  logic [BASE_W-1:0] pageBase;

  // serial clock count within one selection, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      selPrev <= 1'b0;
    end else begin
      selPrev <= selActive;
      if (!selActive) bitCnt <= '0;
      else if (bitTick && bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign deselEvent = selPrev && !selActive;

  always_comb begin
    legalCount = 1'b0;
    for (int k = 1; k <= PAGE_BYTES; k++) begin
      if (bitCnt == CNT_W'(HDR_BITS + BYTE_W * k)) legalCount = 1'b1;
    end
  end

  // page buffer: slot pointer wraps inside the page
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
      slotPtr   <= '0;
      pageBase  <= '0;
    end else if (ctl.loadBase) begin
      validMask <= '0;
      slotPtr   <= cmdAddr[SLOT_W-1:0];
      pageBase  <= cmdAddr[ADDR_W-1:SLOT_W];
    end else if (ctl.storeByte) begin
      validMask[slotPtr] <= 1'b1;
      slotPtr            <= slotPtr + 1'b1;
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pageBuf[s] <= '0;
      else if (ctl.storeByte && slotPtr == SLOT_W'(s)) pageBuf[s] <= dataByte;
    end
  end

  assign arrWe   = ctl.drainEn && validMask[ctl.drainIdx];
  assign arrAddr = {pageBase, ctl.drainIdx};
  assign arrData = pageBuf[ctl.drainIdx];
endmodule

// File: rtl/pgwr_control.sv
module pgwr_control
  import pgwr_pkg::*;
#(
  parameter int CYC_CLKS   = 500000,
  parameter int PWRUP_CLKS = 250000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    selActive,
  input  logic    wrCmd,
  input  logic    dataValid,
  input  logic    wenSet,
  input  logic    wenClr,
  input  logic    wpN,
  input  logic    deselEvent,
  input  logic    legalCount,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    wenLatch,
  output logic    cmdReject
);
  localparam int TMR_W = $clog2(CYC_CLKS + 1);
  localparam int PU_W  = $clog2(PWRUP_CLKS + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_PROGRAM} wrState_t;

  wrState_t         state, stateNxt;
  logic [TMR_W-1:0] timer;
  logic [PU_W-1:0]  puCnt;
  logic             powered;
  logic             cycleDone;

  assign powered = (puCnt == PU_W'(PWRUP_CLKS));
  assign busy    = (state == ST_PROGRAM);

  always_comb begin
    stateNxt  = state;
    ctl       = '0;
    cycleDone = 1'b0;
    case (state)
      ST_IDLE: begin
        if (wrCmd && selActive && wenLatch && wpN && powered) begin
          stateNxt     = ST_COLLECT;
          ctl.loadBase = 1'b1;
        end
      end
      ST_COLLECT: begin
        if (!wpN) stateNxt = ST_IDLE;
        else if (!selActive)
          stateNxt = (deselEvent && legalCount) ? ST_PROGRAM : ST_IDLE;
        else ctl.storeByte = dataValid;
      end
      ST_PROGRAM: begin
        ctl.drainEn  = (timer < TMR_W'(PAGE_BYTES));
        ctl.drainIdx = timer[SLOT_W-1:0];
        if (timer == TMR_W'(CYC_CLKS - 1)) begin
          cycleDone = 1'b1;
          stateNxt  = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      puCnt     <= '0;
      wenLatch  <= 1'b0;
      cmdReject <= 1'b0;
    end else begin
      state     <= stateNxt;
      timer     <= (state == ST_PROGRAM) ? timer + 1'b1 : '0;
      if (!powered) puCnt <= puCnt + 1'b1;
      cmdReject <= busy && (wrCmd || wenSet || wenClr);
      if (cycleDone) wenLatch <= 1'b0;
      else if (!busy) begin
        if (!wpN) wenLatch <= 1'b0;
        else if (wenSet) wenLatch <= 1'b1;
        else if (wenClr) wenLatch <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pgwr_top.sv
module pgwr_top
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int CYC_CLKS   = 500000,
  parameter int PWRUP_CLKS = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selActive,
  input  logic              bitTick,
  input  logic              wrCmd,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataByte,
  input  logic              wenSet,
  input  logic              wenClr,
  input  logic              wpN,
  output logic              busy,
  output logic              wenLatch,
  output logic              cmdReject,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);
  dpCtrl_t ctl;
  logic    deselEvent;
  logic    legalCount;

  pgwr_control #(.CYC_CLKS(CYC_CLKS), .PWRUP_CLKS(PWRUP_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .selActive(selActive), .wrCmd(wrCmd),
    .dataValid(dataValid), .wenSet(wenSet), .wenClr(wenClr), .wpN(wpN),
    .deselEvent(deselEvent), .legalCount(legalCount), .ctl(ctl),
    .busy(busy), .wenLatch(wenLatch), .cmdReject(cmdReject)
  );

  pgwr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .selActive(selActive), .bitTick(bitTick),
    .cmdAddr(cmdAddr), .dataByte(dataByte), .ctl(ctl),
    .deselEvent(deselEvent), .legalCount(legalCount), .arrWe(arrWe),
    .arrAddr(arrAddr), .arrData(arrData)
  );
endmodule

// File: rtl/pgwr_checker.sv
module pgwr_checker
  import pgwr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CYC_CLKS = 500000
) (
  input logic              clk,
  input logic              rstN,
  input logic              selActive,
  input logic              wenSet,
  input logic              busy,
  input logic              wenLatch,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr
);
  logic [31:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  p_we_in_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == 32'(CYC_CLKS));

  p_wel_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wenLatch);

  p_start_desel_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(selActive));

  p_reject_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wenSet) |=> !$rose(wenLatch));

  p_same_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    (arrWe && $past(arrWe)) |->
      arrAddr[ADDR_W-1:SLOT_W] == $past(arrAddr[ADDR_W-1:SLOT_W]));
endmodule

bind pgwr_top pgwr_checker #(.ADDR_W(ADDR_W), .CYC_CLKS(CYC_CLKS)) u_chk (
  .clk(clk), .rstN(rstN), .selActive(selActive), .wenSet(wenSet),
  .busy(busy), .wenLatch(wenLatch), .arrWe(arrWe), .arrAddr(arrAddr)
);

// File: tb/pgwr_top_bench.sv
module pgwr_top_bench;
  localparam int CYC   = 40;
  localparam int PWRUP = 150;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selActive = 1'b0, bitTick = 1'b0, wrCmd = 1'b0, dataValid = 1'b0;
  logic wenSet = 1'b0, wenClr = 1'b0, wpN = 1'b1;
  logic [7:0] cmdAddr = '0, dataByte = '0;
  logic busy, wenLatch, cmdReject, arrWe;
  logic [7:0] arrAddr, arrData;

  int errors = 0;
  int checks = 0;
  int wrCount = 0;
  bit expWel = 0;
  bit powered = 0;
  logic [7:0] expMem [256];
  logic [7:0] obsMem [256];
  logic [7:0] txData [8];

  always #10 clk = ~clk;

  pgwr_top #(.ADDR_W(8), .DATA_W(8), .CYC_CLKS(CYC), .PWRUP_CLKS(PWRUP)) u_pgwr_top (
    .clk(clk), .rstN(rstN), .selActive(selActive), .bitTick(bitTick),
    .wrCmd(wrCmd), .cmdAddr(cmdAddr), .dataValid(dataValid),
    .dataByte(dataByte), .wenSet(wenSet), .wenClr(wenClr), .wpN(wpN),
    .busy(busy), .wenLatch(wenLatch), .cmdReject(cmdReject),
    .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData)
  );

  // array model fed from the write port, sampled away from the edge
  always @(negedge clk) begin
    if (rstN && arrWe) begin
      obsMem[arrAddr] = arrData;
      wrCount++;
    end
  end

  function automatic bit legalCnt(input int n);
    return n >= 24 && n <= 48 && (n % 8) == 0;
  endfunction

  function automatic logic [7:0] slotAddr(input logic [7:0] a, input int i);
    return {a[7:2], 2'(a[1:0] + i)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendBits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bitTick = 1'b1;
      @(negedge clk) bitTick = 1'b0;
    end
  endtask

  task automatic wren();
    @(negedge clk) selActive = 1'b1;
    sendBits(8);
    @(negedge clk) wenSet = 1'b1;
    @(negedge clk) wenSet = 1'b0; selActive = 1'b0;
    @(negedge clk);
    if (wpN) expWel = 1;
  endtask

  task automatic wrdi();
    @(negedge clk) selActive = 1'b1;
    sendBits(8);
    @(negedge clk) wenClr = 1'b1;
    @(negedge clk) wenClr = 1'b0; selActive = 1'b0;
    @(negedge clk);
    expWel = 0;
  endtask

  task automatic xfer(input logic [7:0] addr, input int nb, input int extra,
                      input int cancelAt, input bit poke, input string tag);
    int total;
    bit commit;
    int n;
    total  = 16 + 8 * nb + extra;
    commit = expWel && powered && (cancelAt < 0) && legalCnt(total);
    wrCount = 0;
    @(negedge clk) selActive = 1'b1;
    sendBits(16);
    @(negedge clk) wrCmd = 1'b1; cmdAddr = addr;
    @(negedge clk) wrCmd = 1'b0;
    for (int i = 0; i < nb; i++) begin
      sendBits(8);
      @(negedge clk) dataValid = 1'b1; dataByte = txData[i];
      if (cancelAt == i) wpN = 1'b0;
      @(negedge clk) dataValid = 1'b0; wpN = 1'b1;
    end
    if (cancelAt >= 0) expWel = 0;
    sendBits(extra);
    @(negedge clk) selActive = 1'b0;
    @(negedge clk);
    chk(busy == commit, {tag, " R5 busy after deselect"}, int'(busy), int'(commit));
    if (commit) begin
      n = 0;
      while (busy && n < 10000) begin
        n++;
        if (poke && n == 2) begin wenSet = 1'b1; wpN = 1'b0; end
        if (poke && n == 3) begin
          chk(cmdReject == 1'b1, "R10 cmdReject during cycle", int'(cmdReject), 1);
          wenSet = 1'b0; wpN = 1'b1;
        end
        @(negedge clk);
      end
      chk(n == CYC, "R9 busy length", n, CYC);
      chk(wenLatch == 1'b0, "R11 latch cleared at end", int'(wenLatch), 0);
      expWel = 0;
      for (int i = 0; i < nb; i++) expMem[slotAddr(addr, i)] = txData[i];
      chk(wrCount == nb, {tag, " R7 write count"}, wrCount, nb);
    end else begin
      repeat (4) @(negedge clk);
      chk(wrCount == 0, {tag, " R3 no array write"}, wrCount, 0);
      chk(wenLatch == expWel, {tag, " R5 latch unchanged"}, int'(wenLatch), int'(expWel));
    end
    for (int s = 0; s < 4; s++) begin
      logic [7:0] a;
      a = {addr[7:2], 2'(s)};
      chk(obsMem[a] == expMem[a], {tag, " R6 page contents"}, int'(obsMem[a]), int'(expMem[a]));
    end
  endtask

  task automatic fillData();
    for (int i = 0; i < 8; i++) txData[i] = 8'($urandom_range(0, 255));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd1357);
    for (int i = 0; i < 256; i++) begin expMem[i] = 8'h5A; obsMem[i] = 8'h5A; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && wenLatch == 0 && cmdReject == 0 && arrWe == 0, "R1 reset outputs",
        int'({busy, wenLatch, cmdReject, arrWe}), 0);

    // R2 latch set, R4 lockout before power-up time
    wren();
    chk(wenLatch == 1'b1, "R2 latch set", int'(wenLatch), 1);
    fillData();
    xfer(8'h40, 1, 0, -1, 0, "R4");
    repeat (PWRUP) @(negedge clk);
    powered = 1;

    // legal single-byte write
    fillData();
    xfer(8'h10, 1, 0, -1, 0, "R9");
    // no latch: ignored
    fillData();
    xfer(8'h14, 2, 0, -1, 0, "R3");
    // illegal count then full page
    wren();
    fillData();
    xfer(8'h80, 4, 3, -1, 0, "R5");
    xfer(8'h80, 4, 0, -1, 0, "R7");
    // wrap within page from offset 2
    wren();
    fillData();
    xfer(8'h22, 3, 0, -1, 0, "R6");
    // latch clear paths
    wren();
    wrdi();
    chk(wenLatch == 1'b0, "R2 latch cleared by disable", int'(wenLatch), 0);
    wren();
    @(negedge clk) wpN = 1'b0;
    @(negedge clk) wpN = 1'b1;
    expWel = 0;
    @(negedge clk);
    chk(wenLatch == 1'b0, "R2 latch cleared by protect", int'(wenLatch), 0);
    // cancel while collecting
    wren();
    fillData();
    xfer(8'h30, 2, 0, 1, 0, "R8");
    chk(wenLatch == 1'b0, "R8 cancel clears latch", int'(wenLatch), 0);
    // protect and commands during a running cycle
    wren();
    fillData();
    xfer(8'h51, 2, 0, -1, 1, "R8");
    chk(wenLatch == 1'b0, "R10 set during cycle had no effect", int'(wenLatch), 0);

    // random traffic
    for (int t = 0; t < 30; t++) begin
      logic [7:0] a;
      int nb;
      int extra;
      a = 8'($urandom_range(0, 255));
      nb = $urandom_range(1, 5);
      extra = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      if ($urandom_range(0, 3) != 0) wren();
      fillData();
      xfer(a, nb, extra, -1, 0, "R5");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule